// File: doc/BRIEF.md
# Memory Clock Halt Controller

This block sits between the command scheduler of a low-power DDR memory controller and the stage that gates the memory clock. It takes one access command at a time from the scheduler. From the command code it loads a per-command completion window, counted in controller clock cycles, and holds back any further command until that window has run out. When the scheduler raises a halt request and nothing is pending, the block stops the memory clock as soon as the last command's window has expired. At that point the device rests in the idle or row-active state.

While halted, the true clock rests low and the complementary clock rests high. The clock enable to the memory stays high the whole time, so this mode never overlaps with power-down. A pending command, or a withdrawn halt request, restarts the clock. The block then keeps the command bus at NOP for a fixed number of cycles (one mandatory cycle plus a parameterised margin) before it again reports ready. The gating enable is retimed on the falling edge, so the gated clock never carries a partial pulse.

Top module: `memclk_stop_ctrl`

## Requirements
- R1: After reset (asynchronous, active low) the clock runs: `clkHalted`=0, `clkGateEn`=1, and `cmdReady`=1. The same holds when reset is applied while halted.
- R2: A command accepted on a clock edge (`cmdValid`=1 and `cmdReady`=1) loads a window of N cycles, selected by `cmdCode`: 1=ACTIVE (TRCD), 3=WRITE (TWR), 4=PRECHARGE (TPRE), 5=AUTO REFRESH (TRFC), 6=MODE SET (TMRD). Codes 0 (NOP) and 7 have N=0. With a halt request held from then on, `clkHalted` rises on the edge N+1 cycles after the accept edge.
- R3: The window of READ (code 2) is CAS_LAT + BURST_LEN/2 cycles, so that read data return is covered.
- R4: `cmdReady` stays low for the N cycles after an accept, so the bus carries NOP until the window ends.
- R5: A halt is entered only when `stopReq`=1 and `cmdValid`=0. When both are high in the same cycle, the command is accepted and the clock keeps running.
- R6: While halted, `clkGateEn`=0, `memCk` rests low and `memCkN` rests high, in both phases of the controller clock.
- R7: `ckeOut` is 1 at all times, including while halted.
- R8: A halt ends when `cmdValid`=1 or `stopReq`=0. After the exit edge, `cmdReady` stays low for exactly 1+EXTRA_NOP cycles while the clock runs.
- R9: `clkGateEn` changes only on the falling edge of `clk`. On the edge that enters the halt, it stays 1 through the high phase and drops in the following low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; source of the memory clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Scheduler has a command pending; wakes a halted clock |
| cmdCode | input | 3 | Code of the pending command |
| stopReq | input | 1 | Request to halt the memory clock when legal |
| cmdReady | output | 1 | Pending command is accepted on this edge |
| clkGateEn | output | 1 | Enable to the glitch-free clock gate, retimed on the falling edge |
| memCk | output | 1 | Gated true memory clock |
| memCkN | output | 1 | Gated complementary memory clock |
| ckeOut | output | 1 | Memory clock enable, held high |
| clkHalted | output | 1 | Memory clock is halted |

## Verification
A halt request and a new command can both be raised in a cycle where the window has expired. In that cycle the block must either accept the command or halt, never both. The bench raises `stopReq` and `cmdValid` on the same edge. It then checks that the clock still runs, that `cmdReady` drops for the new window, and that the halt follows only after that window. The other overlap is a wake-up that coincides with a held halt request; the bench judges it by counting the NOP cycles before `cmdReady` returns.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_REF   = 3'd5,
    CMD_MRS   = 3'd6,
    CMD_OTHER = 3'd7
  } memCmd_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_WAKE = 2'd2
  } haltState_e;

  typedef struct packed {
    logic loadBusy;
    logic loadNop;
    logic runClk;
  } haltStrobe_t;

endpackage

// File: rtl/clkstop_datapath.sv
module clkstop_datapath
  import clkstop_pkg::*;
#(
  parameter int TRCD      = 3,
  parameter int TWR       = 2,
  parameter int TPRE      = 3,
  parameter int TRFC      = 10,
  parameter int TMRD      = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int EXTRA_NOP = 0
) (
  input  logic        clk,
  input  logic        rstN,
  input  haltStrobe_t strobe,
  input  logic [2:0]  cmdCode,
  output logic        busyZero,
  output logic        nopLast,
  output logic        gateEn
);

  localparam int RD_WIN = CAS_LAT + BURST_LEN / 2;
  localparam int MAX_A  = (TRCD > TWR) ? TRCD : TWR;
  localparam int MAX_B  = (TPRE > TRFC) ? TPRE : TRFC;
  localparam int MAX_C  = (TMRD > RD_WIN) ? TMRD : RD_WIN;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_W  = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CW     = $clog2(MAX_W + 1);
  localparam int NOP_CYCLES = 1 + EXTRA_NOP;
  localparam int NW     = $clog2(NOP_CYCLES + 1);

  logic [CW-1:0] winVal;
  logic [CW-1:0] busyCnt;
  logic [NW-1:0] nopCnt;

  // Window per command code
  always_comb begin
    case (memCmd_e'(cmdCode))
      CMD_ACT: winVal = CW'(TRCD);
      CMD_RD:  winVal = CW'(RD_WIN);
      CMD_WR:  winVal = CW'(TWR);
      CMD_PRE: winVal = CW'(TPRE);
      CMD_REF: winVal = CW'(TRFC);
      CMD_MRS: winVal = CW'(TMRD);
      default: winVal = '0;
    endcase
  end

  assign busyZero = (busyCnt == '0);
  assign nopLast  = (nopCnt == NW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strobe.loadBusy) begin
      busyCnt <= winVal;
    end else if (!busyZero) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nopCnt <= '0;
    end else if (strobe.loadNop) begin
      nopCnt <= NW'(NOP_CYCLES);
    end else if (nopCnt != '0) begin
      nopCnt <= nopCnt - 1'b1;
    end
  end

  // Enable retimed in the low phase so the gated clock never glitches
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      gateEn <= 1'b1;
    end else begin
      gateEn <= strobe.runClk;
    end
  end

  // R4
  busy_idle_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBusy |-> busyZero);

  // R8
  nop_idle_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNop |-> (nopCnt == '0));

endmodule

// File: rtl/clkstop_control.sv
module clkstop_control
  import clkstop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        stopReq,
  input  logic        busyZero,
  input  logic        nopLast,
  output haltStrobe_t strobe,
  output logic        cmdReady,
  output logic        halted
);

  haltState_e state;
  haltState_e stateNext;
  logic       wakeCause;

  assign wakeCause = cmdValid || !stopReq;
  assign cmdReady  = (state == ST_RUN) && busyZero;
  assign halted    = (state == ST_HALT);

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:  if (busyZero && stopReq && !cmdValid) stateNext = ST_HALT;
      ST_HALT: if (wakeCause) stateNext = ST_WAKE;
      ST_WAKE: if (nopLast) stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    strobe.loadBusy = cmdValid && cmdReady;
    strobe.loadNop  = (state == ST_HALT) && wakeCause;
    strobe.runClk   = (state != ST_HALT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  // R2
  halt_needs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> busyZero);

  // R5
  halt_entry_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> ($past(stopReq) && !$past(cmdValid)));

  // R8
  wake_nop_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> !cmdReady);

  // R4
  ready_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busyZero |-> !strobe.loadBusy);

endmodule

// File: rtl/memclk_stop_ctrl.sv
module memclk_stop_ctrl
  import clkstop_pkg::*;
#(
  parameter int TRCD      = 3,
  parameter int TWR       = 2,
  parameter int TPRE      = 3,
  parameter int TRFC      = 10,
  parameter int TMRD      = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int EXTRA_NOP = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       stopReq,
  output logic       cmdReady,
  output logic       clkGateEn,
  output logic       memCk,
  output logic       memCkN,
  output logic       ckeOut,
  output logic       clkHalted
);

  haltStrobe_t strobe;
  logic        busyZero;
  logic        nopLast;

  clkstop_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .stopReq  (stopReq),
    .busyZero (busyZero),
    .nopLast  (nopLast),
    .strobe   (strobe),
    .cmdReady (cmdReady),
    .halted   (clkHalted)
  );

  clkstop_datapath #(
    .TRCD      (TRCD),
    .TWR       (TWR),
    .TPRE      (TPRE),
    .TRFC      (TRFC),
    .TMRD      (TMRD),
    .CAS_LAT   (CAS_LAT),
    .BURST_LEN (BURST_LEN),
    .EXTRA_NOP (EXTRA_NOP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmdCode  (cmdCode),
    .busyZero (busyZero),
    .nopLast  (nopLast),
    .gateEn   (clkGateEn)
  );

  assign memCk  = clk & clkGateEn;
  assign memCkN = ~memCk;
  assign ckeOut = 1'b1;

  // R6
  halt_gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkHalted && $past(clkHalted)) |-> !clkGateEn);

endmodule

// File: tb/sim_memclk_stop_ctrl.sv
module sim_memclk_stop_ctrl;

  localparam int TRCD = 3, TWR = 2, TPRE = 3, TRFC = 10, TMRD = 2;
  localparam int CAS_LAT = 3, BURST_LEN = 4, EXTRA_NOP = 0;
  localparam int RD_WIN = CAS_LAT + BURST_LEN / 2;
  localparam int NVEC = 8;
  localparam int VEC_CODE [NVEC] = '{1, 2, 3, 4, 5, 6, 0, 7};
  localparam int VEC_WIN  [NVEC] = '{TRCD, RD_WIN, TWR, TPRE, TRFC, TMRD, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic stopReq = 1'b0;
  logic cmdReady, clkGateEn, memCk, memCkN, ckeOut, clkHalted;

  int nChecks = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  memclk_stop_ctrl #(
    .TRCD(TRCD), .TWR(TWR), .TPRE(TPRE), .TRFC(TRFC), .TMRD(TMRD),
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .EXTRA_NOP(EXTRA_NOP)
  ) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .stopReq(stopReq), .cmdReady(cmdReady), .clkGateEn(clkGateEn),
    .memCk(memCk), .memCkN(memCkN), .ckeOut(ckeOut), .clkHalted(clkHalted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // From a ready sample point (+7): halt request held, count edges to halt
  task automatic runToHalt(input int win, input string req);
    int k;
    logic gHigh;
    k = 0;
    gHigh = 1'b1;
    while (k < 64) begin
      #6;
      if (clkHalted) break;
      if (k < win) chk(!cmdReady, "R4 ready low in window", int'(cmdReady), 0);
      @(posedge clk); #1;
      gHigh = clkGateEn;
      k++;
    end
    chk(k == win + 1, req, k, win + 1);
    chk(gHigh == 1'b1, "R9 enable held in high phase", int'(gHigh), 1);
    chk(!clkGateEn && !memCk && memCkN, "R6 rest levels low phase",
        {clkGateEn, memCk, memCkN}, 1);
    chk(ckeOut == 1'b1, "R7 cke high while halted", int'(ckeOut), 1);
    @(posedge clk); #1;
    chk(clkHalted && !memCk && memCkN, "R6 rest levels high phase",
        {clkHalted, memCk, memCkN}, 5);
    #6;
  endtask

  // From a halted sample point (+7): wake and count NOP cycles
  task automatic wakeUp(input bit byCmd);
    int nops;
    @(posedge clk); #1;
    if (byCmd) cmdValid = 1'b1; else stopReq = 1'b0;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    stopReq = 1'b0;
    nops = 0;
    while (nops < 64) begin
      #6;
      if (cmdReady) break;
      chk(!clkHalted && clkGateEn, "R8 clock runs during NOP phase",
          {clkHalted, clkGateEn}, 1);
      @(posedge clk); #1;
      nops++;
    end
    chk(nops == 1 + EXTRA_NOP, byCmd ? "R8 NOP cycles after cmd wake" :
        "R8 NOP cycles after request drop", nops, 1 + EXTRA_NOP);
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #6;
    // R1 reset state
    chk(!clkHalted && clkGateEn && cmdReady, "R1 reset state",
        {clkHalted, clkGateEn, cmdReady}, 3);
    chk(ckeOut == 1'b1, "R7 cke high after reset", int'(ckeOut), 1);

    // Vector walk: R2 and R3 per command window
    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1;
      cmdValid = 1'b1;
      cmdCode = 3'(VEC_CODE[i]);
      #6;
      chk(cmdReady, "R4 ready before accept", int'(cmdReady), 1);
      @(posedge clk); #1;
      cmdValid = 1'b0;
      stopReq = 1'b1;
      runToHalt(VEC_WIN[i], (VEC_CODE[i] == 2) ? "R3 read window" : "R2 command window");
      wakeUp(i % 2 == 1);
    end

    // R5 conflict: halt request and command on the same edge
    @(posedge clk); #1;
    cmdValid = 1'b1;
    cmdCode = 3'd4;
    stopReq = 1'b1;
    #6;
    chk(cmdReady, "R5 ready at conflict", int'(cmdReady), 1);
    @(posedge clk); #1;
    cmdValid = 1'b0;
    chk(!clkHalted && clkGateEn, "R5 command wins over halt",
        {clkHalted, clkGateEn}, 1);
    #6;
    chk(!cmdReady && !clkHalted, "R5 window started",
        {cmdReady, clkHalted}, 0);
    @(posedge clk); #1;
    runToHalt(TPRE - 1, "R2 halt after conflict command");

    // R1 reset while halted
    @(posedge clk); #1;
    rstN = 1'b0;
    #1;
    chk(!clkHalted && clkGateEn, "R1 reset while halted",
        {clkHalted, clkGateEn}, 1);
    stopReq = 1'b0;
    @(posedge clk); #1;
    rstN = 1'b1;
    #6;
    chk(cmdReady && !clkHalted, "R1 ready after second reset",
        {cmdReady, clkHalted}, 2);

    // R5 no halt without request
    repeat (4) @(posedge clk);
    #7;
    chk(!clkHalted, "R5 no halt without request", int'(clkHalted), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule